// File: doc/BRIEF.md
# Instruction Pump with Sealable Hatch

This block is the instruction front end of a programmable dock. Instruction words arrive on a valid/ready stream and are parked in an entry FIFO. A two-state gate (the hatch) sits between that entry FIFO and a circular instruction FIFO. The head of the instruction FIFO feeds a single on-deck register, which presents one instruction at a time to the execution logic. The execution logic answers with a one-cycle completion pulse.

A loop body is held by recirculation. An on-deck instruction that qualifies is copied back to the tail of the instruction FIFO once the hatch is sealed. A special tail word seals the hatch and is then discarded. New code therefore waits in the entry FIFO until the loop ends. The loop ends when the outer loop counter is cleared, and that event unseals the hatch. The block decodes only two fields: the one-shot bit and the tail code.

Top module: `instr_pump`

## Requirements
- R1: After reset no instruction is on deck, the input is ready, and the hatch is unsealed, so the first word pushed reaches on deck.
- R2: A word accepted at clock edge k is shown on deck at edge k+2 when both FIFOs and the on-deck stage are empty and the hatch is unsealed. Words reach on deck in the order they were accepted.
- R3: A word whose bits [25:24] equal 2'b11 is a tail. It never appears on deck. When it reaches the entry FIFO head with the hatch unsealed, it is dropped and the hatch becomes sealed.
- R4: While the hatch is sealed, words behind a tail stay in the entry FIFO and do not reach on deck.
- R5: A one-cycle pulse on `olc_cleared` unseals the hatch, and the waiting words then flow. If a tail is dropped in the same cycle as the pulse, the hatch ends up sealed.
- R6: An on-deck word is copied back to the instruction FIFO tail once the hatch is sealed, provided two conditions held in the cycle it came on deck: `olc_zero` was low and its one-shot bit (bit 23) was clear. The copy comes on deck again in FIFO order.
- R7: A word that came on deck while `olc_zero` was high, or whose bit 23 is set, is not recirculated.
- R8: The on-deck word stays valid and unchanged until two things have happened: `od_done` has been seen, and any pending recirculation has completed. A new word comes on deck only after a cycle with no word on deck.
- R9: A recirculation attempted while the instruction FIFO is full stalls the on-deck stage. It does not drop the word.
- R10: When the entry FIFO holds EF_DEPTH words, `in_ready` is low and no further word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming instruction word valid |
| in_ready | output | 1 | Entry FIFO has room |
| in_word | input | 26 | Incoming instruction word |
| olc_zero | input | 1 | Outer loop counter is currently zero |
| olc_cleared | input | 1 | Pulse: outer loop counter was just set to zero |
| od_valid | output | 1 | An instruction is on deck |
| od_word | output | 26 | On-deck instruction |
| od_done | input | 1 | Execution of the on-deck instruction has completed |

## Verification
An accepted word is due on deck two edges later: one edge moves it through the hatch and one loads the on-deck register. A recirculation happens on the first edge at which the hatch is sealed, and a retired word leaves one empty cycle before its successor loads. The bench drives and samples at falling edges, so each check reads values that settled after the rising edge it is counting. Hatch-hold and stall checks wait a fixed number of cycles and confirm that nothing moved. Ordering checks pop an expected queue each time a new word appears on deck.

// File: rtl/instr_pump.sv
module instr_pump #(
  parameter int W         = 26,
  parameter int EF_DEPTH  = 8,
  parameter int IF_DEPTH  = 8,
  parameter int OS_BIT    = 23,
  parameter logic [1:0] TAIL_CODE = 2'b11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_word,
  input  logic         olc_zero,
  input  logic         olc_cleared,
  output logic         od_valid,
  output logic [W-1:0] od_word,
  input  logic         od_done
);
  localparam int EPW = (EF_DEPTH > 1) ? $clog2(EF_DEPTH) : 1;
  localparam int IPW = (IF_DEPTH > 1) ? $clog2(IF_DEPTH) : 1;
  localparam int ECW = $clog2(EF_DEPTH + 1);
  localparam int ICW = $clog2(IF_DEPTH + 1);

  logic [W-1:0]   ef_mem [EF_DEPTH];
  logic [W-1:0]   if_mem [IF_DEPTH];
  logic [EPW-1:0] ef_rd, ef_wr;
  logic [IPW-1:0] if_rd, if_wr;
  logic [ECW-1:0] ef_cnt;
  logic [ICW-1:0] if_cnt;
  logic           sealed, req_pending, exec_seen;

  logic [W-1:0] ef_head, if_wdata;
  logic ef_push, head_tail, tail_pop, xfer, ef_pop;
  logic if_full, requeue, if_push, if_pop, retire;

  assign in_ready  = ef_cnt != ECW'(EF_DEPTH);
  assign ef_push   = in_valid && in_ready;
  assign ef_head   = ef_mem[ef_rd];
  assign head_tail = (ef_cnt != '0) && (ef_head[W-1:W-2] == TAIL_CODE);
  assign if_full   = if_cnt == ICW'(IF_DEPTH);
  assign tail_pop  = head_tail && !sealed;
  assign xfer      = (ef_cnt != '0) && !head_tail && !sealed && !if_full;
  assign ef_pop    = xfer || tail_pop;
  assign requeue   = od_valid && req_pending && sealed && !if_full;
  assign if_push   = xfer || requeue;
  assign if_wdata  = requeue ? od_word : ef_head;
  assign if_pop    = !od_valid && (if_cnt != '0);
  assign retire    = od_valid && (exec_seen || od_done) && (!req_pending || requeue);

  always_ff @(posedge clk) begin
    if (ef_push) ef_mem[ef_wr] <= in_word;
    if (if_push) if_mem[if_wr] <= if_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ef_rd <= '0; ef_wr <= '0; ef_cnt <= '0;
      if_rd <= '0; if_wr <= '0; if_cnt <= '0;
      sealed <= 1'b0;
    end else begin
      if (ef_push) ef_wr <= (ef_wr == EPW'(EF_DEPTH-1)) ? '0 : ef_wr + 1'b1;
      if (ef_pop)  ef_rd <= (ef_rd == EPW'(EF_DEPTH-1)) ? '0 : ef_rd + 1'b1;
      if (if_push) if_wr <= (if_wr == IPW'(IF_DEPTH-1)) ? '0 : if_wr + 1'b1;
      if (if_pop)  if_rd <= (if_rd == IPW'(IF_DEPTH-1)) ? '0 : if_rd + 1'b1;
      ef_cnt <= ef_cnt + ECW'(ef_push) - ECW'(ef_pop);
      if_cnt <= if_cnt + ICW'(if_push) - ICW'(if_pop);
      sealed <= tail_pop || (sealed && !olc_cleared);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      od_valid    <= 1'b0;
      od_word     <= '0;
      req_pending <= 1'b0;
      exec_seen   <= 1'b0;
    end else if (if_pop) begin
      od_valid    <= 1'b1;
      od_word     <= if_mem[if_rd];
      req_pending <= !olc_zero && !if_mem[if_rd][OS_BIT];
      exec_seen   <= 1'b0;
    end else if (retire) begin
      od_valid    <= 1'b0;
      req_pending <= 1'b0;
      exec_seen   <= 1'b0;
    end else if (od_valid) begin
      if (od_done) exec_seen   <= 1'b1;
      if (requeue) req_pending <= 1'b0;
    end
  end
endmodule

// File: rtl/instr_pump_chk.sv
module instr_pump_chk #(
  parameter int W        = 26,
  parameter int EF_DEPTH = 8,
  parameter int IF_DEPTH = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         olc_cleared,
  input logic         od_valid,
  input logic [W-1:0] od_word,
  input logic         sealed,
  input logic         req_pending,
  input logic [$clog2(EF_DEPTH+1)-1:0] ef_cnt,
  input logic [$clog2(IF_DEPTH+1)-1:0] if_cnt
);
  a_r1_reset_empty: assert property (@(posedge clk) !rst_n |=> !od_valid);

  a_r3_no_tail_on_deck: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid |-> od_word[W-1:W-2] != 2'b11);

  a_r4_sealed_holds_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sealed && !olc_cleared) |=> ef_cnt >= $past(ef_cnt));

  a_r8_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    od_valid |=> (!od_valid || $stable(od_word)));

  a_r8_pending_keeps_deck: assert property (@(posedge clk) disable iff (!rst_n)
    (od_valid && req_pending && !sealed) |=> od_valid);

  a_r9_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (od_valid && req_pending && if_cnt == ($clog2(IF_DEPTH+1))'(IF_DEPTH)) |=> (od_valid && req_pending));

  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    ef_cnt <= ($clog2(EF_DEPTH+1))'(EF_DEPTH) && if_cnt <= ($clog2(IF_DEPTH+1))'(IF_DEPTH));
endmodule

bind instr_pump instr_pump_chk #(.W(W), .EF_DEPTH(EF_DEPTH), .IF_DEPTH(IF_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .olc_cleared(olc_cleared), .od_valid(od_valid),
  .od_word(od_word), .sealed(sealed), .req_pending(req_pending),
  .ef_cnt(ef_cnt), .if_cnt(if_cnt)
);

// File: tb/instr_pump_tb_top.sv
module instr_pump_tb_top;
  localparam int W = 26;
  localparam int EFD = 8;
  localparam int IFD = 8;
  localparam logic [W-1:0] TAILW = 26'h3000000;
  localparam logic [W-1:0] OSB   = 26'h0800000;

  logic clk = 0, rst_n = 0, in_valid = 0, olc_zero = 1, olc_cleared = 0, od_done = 0;
  logic [W-1:0] in_word = '0;
  logic in_ready, od_valid;
  logic [W-1:0] od_word;

  always #5 clk = ~clk;

  instr_pump dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .olc_zero(olc_zero), .olc_cleared(olc_cleared),
    .od_valid(od_valid), .od_word(od_word), .od_done(od_done));

  logic [W-1:0] exp_q[$];
  int n_chk = 0, n_fail = 0, m_chk = 0, m_fail = 0, seen = 0;
  bit hold = 0, got = 0, wd_fail = 0, ended = 0;

  // monitor: compares every word that newly appears on deck and answers with od_done
  always @(negedge clk) begin
    od_done = 0;
    if (!rst_n || !od_valid) got = 0;
    else if (!got && !hold) begin
      got = 1; od_done = 1; seen++; m_chk++;
      if (exp_q.size() == 0) begin
        m_fail++;
        $display("FAIL R3 unexpected on-deck word got %h expected none", od_word);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        if (od_word !== e) begin
          m_fail++;
          $display("FAIL R2 on-deck order got %h expected %h", od_word, e);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic push(input logic [W-1:0] w, input bit expect_it);
    in_valid = 1; in_word = w;
    if (expect_it) exp_q.push_back(w);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pulse_clear();
    olc_cleared = 1; @(negedge clk); olc_cleared = 0;
  endtask

  task automatic drain();
    for (int i = 0; i < 300 && exp_q.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic report();
    int tot, bad;
    if (!ended) begin
      ended = 1;
      tot = n_chk + m_chk + int'(wd_fail);
      bad = n_fail + m_fail + int'(wd_fail);
      $display("%0d/%0d checks passed", tot - bad, tot);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    wd_fail = 1;
    $display("FAIL watchdog expired got running expected finished");
    report();
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    chk(od_valid == 0, "R1 od_valid in reset", od_valid, 0);
    rst_n = 1;
    @(negedge clk);
    chk(od_valid == 0, "R1 od_valid after reset", od_valid, 0);
    chk(in_ready == 1, "R1 in_ready after reset", in_ready, 1);

    // R2 latency: accepted at edge k, on deck at k+2
    push(26'h0000D1, 1);
    chk(od_valid == 0, "R2 latency k", od_valid, 0);
    @(negedge clk);
    chk(od_valid == 0, "R2 latency k+1", od_valid, 0);
    @(negedge clk);
    chk(od_valid == 1 && od_word == 26'h0000D1, "R1 R2 latency k+2", od_word, 26'h0000D1);
    drain();

    // R2 ordering, no recirculation since olc_zero is high
    push(26'h0000A1, 1); push(26'h0000B2, 1); push(26'h0000C3, 1);
    drain();
    chk(exp_q.size() == 0, "R2 in-order delivery", exp_q.size(), 0);

    // R3 R4 tail seals, later word waits
    s0 = seen;
    push(TAILW | 26'h5, 0); push(26'h0000E4, 1);
    repeat (10) @(negedge clk);
    chk(od_valid == 0, "R4 word held behind sealed hatch", od_valid, 0);
    chk(seen == s0, "R3 R4 nothing on deck while sealed", seen, s0);
    pulse_clear();
    drain();
    chk(exp_q.size() == 0 && seen == s0 + 1, "R5 clear releases word", seen, s0 + 1);

    // R5 tail drop in the same cycle as the clear pulse keeps the hatch sealed
    push(TAILW, 0);
    pulse_clear();
    s0 = seen;
    push(26'h0000F5, 1);
    repeat (10) @(negedge clk);
    chk(od_valid == 0 && seen == s0, "R5 tail wins over clear", seen, s0);
    pulse_clear();
    drain();
    chk(exp_q.size() == 0, "R5 second clear releases word", exp_q.size(), 0);

    // R6 R7 loop: L1,L2 recirculate, L3 one-shot
    olc_zero = 0;
    s0 = seen;
    exp_q.push_back(26'h11); exp_q.push_back(26'h12); exp_q.push_back(OSB | 26'h13);
    exp_q.push_back(26'h11); exp_q.push_back(26'h12);
    exp_q.push_back(26'h11); exp_q.push_back(26'h12);
    exp_q.push_back(26'h11); exp_q.push_back(26'h12);
    exp_q.push_back(26'h0000AA);
    push(26'h11, 0); push(26'h12, 0); push(OSB | 26'h13, 0); push(TAILW, 0); push(26'h0000AA, 0);
    wait (seen == s0 + 7);
    olc_zero = 1;
    olc_cleared = 1;
    @(negedge clk);
    olc_cleared = 0;
    drain();
    chk(exp_q.size() == 0, "R6 loop sequence complete", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    chk(od_valid == 0 && seen == s0 + 10, "R7 no recirculation after olc_zero", seen, s0 + 10);

    // R10 entry FIFO full
    hold = 1;
    push(TAILW, 0);
    for (int i = 0; i < EFD; i++) push(26'h000100 + W'(i), 1);
    chk(in_ready == 0, "R10 in_ready low when entry full", in_ready, 0);
    chk(od_valid == 0, "R4 nothing on deck with full sealed entry", od_valid, 0);
    hold = 0;
    pulse_clear();
    drain();
    chk(exp_q.size() == 0, "R10 all held words delivered", exp_q.size(), 0);

    // R9 recirculation into a full instruction FIFO stalls
    olc_zero = 0;
    hold = 1;
    for (int i = 0; i <= IFD; i++) push(26'h000200 + W'(i), i == 0);
    push(TAILW, 0);
    repeat (20) @(negedge clk);
    hold = 0;
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R9 first word executed", exp_q.size(), 0);
    chk(od_valid == 1 && od_word == 26'h000200, "R9 stalled word kept on deck", od_word, 26'h000200);
    report();
  end
endmodule